// File: doc/BRIEF.md
# Variable-Block Conditional Carry-Select Adder

A purely combinational 16-bit adder that takes two operands and a carry-in and returns a 16-bit sum and a carry-out. Each bit position forms a generate term (AND of the operand bits) and a propagate term (OR of the operand bits). The bit positions are grouped into carry blocks. Every block computes its internal carries twice in parallel: once assuming its incoming carry is 0 and once assuming it is 1. A row of multiplexers then keeps one of the two carry vectors. Every multiplexer in a block is steered by the single carry leaving the previous block. The first block is steered by the external carry-in.

An elaboration-time parameter picks the partition. The uniform partition has four blocks of four bits. The growing partition has five blocks whose widths rise along the word: 1, 2, 3, 4 and 6 bits. Because the later blocks are wider, they have more time to precompute both carry cases before their select carry arrives. The block has no state and no runtime control. Two instances can be chained into a 32-bit adder by feeding the carry-out of the lower one into the carry-in of the upper one.

Top module: `csel_adder16`

## Requirements
- R1: For each bit i, G(i) = a(i) AND b(i), P(i) = a(i) OR b(i), and carry C(i) = G(i) OR (C(i-1) AND P(i)), with C(-1) = cin. For example, a = 0x0001, b = 0x0001, cin = 0 gives sum 0x0002.
- R2: With MODE = CS_UNIFORM (blocks of bits 0-3, 4-7, 8-11, 12-15), {cout, sum} equals a + b + cin for every input.
- R3: With MODE = CS_GROWING (blocks of bits 0, 1-2, 3-5, 6-9, 10-15), {cout, sum} equals a + b + cin for every input.
- R4: The longest-path pattern a = 0x0001, b = 0xFFFF, cin = 0 gives sum 0x0000 and cout 1 in both modes.
- R5: The external carry-in steers the first block. a = 0xFFFF, b = 0x0000 gives sum 0x0000 and cout 1 when cin = 1, and gives sum 0xFFFF and cout 0 when cin = 0.
- R6: All-zero operands give sum equal to cin and cout 0. All-one operands give sum 0xFFFE + cin and cout 1.
- R7: A carry generated at any bit k from 0 to 14 lands at bit k+1, including across every block boundary. Setting a = b = 1<<k with cin = 0 gives sum 1<<(k+1) and cout 0. At k = 15 the result is sum 0 and cout 1.
- R8: Two instances chained through the carry, with the lower instance's cout driving the upper instance's cin, produce the correct 33-bit result of a 32-bit addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_op | input | 16 | First operand |
| b_op | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The embedded checks are combinational and assume settled, fully known operand and carry-in values. They do not hold for unknown or mid-change inputs. The bench therefore drives every input vector a full half clock period before it samples anything. It never leaves an input undriven. The stimulus combines directed vectors with a long run of seeded random vectors. The directed vectors cover the longest path, carry-in steering, carries at block boundaries and the all-zero and all-one operands. The random vectors exercise both partitions and the 32-bit chain.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int CS_W          = 16;
    localparam int CS_UBLK       = 4;
    localparam int CS_GROW_STEPS = 4;

    typedef enum logic {
        CS_UNIFORM = 1'b0,
        CS_GROWING = 1'b1
    } cs_part_e;

    function automatic int cs_blk_cnt(cs_part_e m);
        return (m == CS_UNIFORM) ? (CS_W / CS_UBLK) : (CS_GROW_STEPS + 1);
    endfunction

    function automatic int cs_blk_len(cs_part_e m, int k);
        int used;
        if (m == CS_UNIFORM) return CS_UBLK;
        if (k < CS_GROW_STEPS) return k + 1;
        used = 0;
        for (int j = 0; j < CS_GROW_STEPS; j++) used += j + 1;
        return CS_W - used;
    endfunction

    function automatic int cs_blk_lo(cs_part_e m, int k);
        int lo;
        lo = 0;
        for (int j = 0; j < k; j++) lo += cs_blk_len(m, j);
        return lo;
    endfunction

endpackage

// File: rtl/csel_gp.sv
module csel_gp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_op,
    input  logic [W-1:0] b_op,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] half
);

    always_comb begin
        gen  = a_op & b_op;
        prop = a_op | b_op;
        half = a_op ^ b_op;
    end

    always_comb begin
        AST_GEN_IMPLIES_PROP: assert ((gen & ~prop) == '0); // R1
        AST_HALF_INSIDE_PROP: assert ((half & ~prop) == '0); // R1
    end

endmodule

// File: rtl/csel_block.sv
module csel_block #(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] gen,
    input  logic [LEN-1:0] prop,
    output logic [LEN-1:0] c_if0,
    output logic [LEN-1:0] c_if1
);

    always_comb begin
        logic r0;
        logic r1;
        r0 = 1'b0;
        r1 = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            r0 = gen[i] | (r0 & prop[i]);
            r1 = gen[i] | (r1 & prop[i]);
            c_if0[i] = r0;
            c_if1[i] = r1;
        end
    end

    // A carry seen when the assumed input carry is 0 must also be seen when it is 1
    always_comb begin
        AST_PRECOMP_ORDER: assert ((c_if0 & ~c_if1) == '0); // R1
    end

endmodule

// File: rtl/csel_adder16.sv
module csel_adder16
    import csel_pkg::*;
#(
    parameter cs_part_e MODE = CS_GROWING
) (
    input  logic [CS_W-1:0] a_op,
    input  logic [CS_W-1:0] b_op,
    input  logic            cin,
    output logic [CS_W-1:0] sum,
    output logic            cout
);

    localparam int NBLK = cs_blk_cnt(MODE);

    logic [CS_W-1:0] gen_all;
    logic [CS_W-1:0] prop_all;
    logic [CS_W-1:0] half_all;
    logic [CS_W-1:0] c0_all;
    logic [CS_W-1:0] c1_all;
    logic [CS_W:0]   cx;

    csel_gp #(.W(CS_W)) u_gp (
        .a_op (a_op),
        .b_op (b_op),
        .gen  (gen_all),
        .prop (prop_all),
        .half (half_all)
    );

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        localparam int LO  = cs_blk_lo(MODE, k);
        localparam int LEN = cs_blk_len(MODE, k);
        csel_block #(.LEN(LEN)) u_blk (
            .gen   (gen_all[LO+LEN-1:LO]),
            .prop  (prop_all[LO+LEN-1:LO]),
            .c_if0 (c0_all[LO+LEN-1:LO]),
            .c_if1 (c1_all[LO+LEN-1:LO])
        );
    end

    // Block selection: each block keeps one precomputed vector, chosen by the
    // last carry of the block below it (cx[lo]); cx[0] is the external carry-in.
    always_comb begin
        cx    = '0;
        cx[0] = cin;
        for (int k = 0; k < NBLK; k++) begin
            int lo;
            int len;
            lo  = cs_blk_lo(MODE, k);
            len = cs_blk_len(MODE, k);
            for (int i = 0; i < len; i++) begin
                cx[lo+i+1] = cx[lo] ? c1_all[lo+i] : c0_all[lo+i];
            end
        end
    end

    always_comb begin
        sum  = half_all ^ cx[CS_W-1:0];
        cout = cx[CS_W];
    end

    always_comb begin
        AST_SUM_EXACT: assert ({cout, sum} == ({1'b0, a_op} + {1'b0, b_op} + {{CS_W{1'b0}}, cin})); // R2
        AST_ZERO_OPERANDS: assert (!((a_op == '0) && (b_op == '0)) || ({cout, sum} == {{CS_W{1'b0}}, cin})); // R6
    end

endmodule

// File: tb/csel_adder16_tb.sv
module csel_adder16_tb;
    import csel_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [15:0] a, b;
    logic        ci;
    logic [15:0] s_uni, s_grw;
    logic        co_uni, co_grw;
    logic [31:0] a32, b32;
    logic        ci32;
    logic [15:0] s_lo, s_hi;
    logic        co_lo, co_hi;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    csel_adder16 #(.MODE(CS_UNIFORM)) u_dut (
        .a_op(a), .b_op(b), .cin(ci), .sum(s_uni), .cout(co_uni));
    csel_adder16 #(.MODE(CS_GROWING)) u_grw (
        .a_op(a), .b_op(b), .cin(ci), .sum(s_grw), .cout(co_grw));
    csel_adder16 #(.MODE(CS_GROWING)) u_lo (
        .a_op(a32[15:0]), .b_op(b32[15:0]), .cin(ci32), .sum(s_lo), .cout(co_lo));
    csel_adder16 #(.MODE(CS_GROWING)) u_hi (
        .a_op(a32[31:16]), .b_op(b32[31:16]), .cin(co_lo), .sum(s_hi), .cout(co_hi));

    function automatic logic [16:0] ref16(logic [15:0] x, logic [15:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    function automatic logic [32:0] ref32(logic [31:0] x, logic [31:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {32'd0, c};
    endfunction

    task automatic chk(string tag, logic [32:0] got, logic [32:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(logic [15:0] x, logic [15:0] y, logic c);
        @(posedge clk);
        a = x; b = y; ci = c;
        @(negedge clk);
    endtask

    task automatic chk_both(string tag, logic [16:0] exp);
        chk({tag, " uniform"}, {16'd0, co_uni, s_uni}, {16'd0, exp});
        chk({tag, " growing"}, {16'd0, co_grw, s_grw}, {16'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] x, y;
        logic        c;
        a = '0; b = '0; ci = 1'b0; a32 = '0; b32 = '0; ci32 = 1'b0;
        void'($urandom(32'h5EED_1234));

        // reset-like idle state: zero inputs
        apply(16'h0000, 16'h0000, 1'b0);
        chk_both("R6 zero idle", 17'h00000);

        apply(16'h0001, 16'h0001, 1'b0);
        chk_both("R1 single generate", 17'h00002);

        apply(16'h0001, 16'hFFFF, 1'b0);
        chk_both("R4 longest path", 17'h10000);

        apply(16'hFFFF, 16'h0000, 1'b1);
        chk_both("R5 cin=1 steer", 17'h10000);
        apply(16'hFFFF, 16'h0000, 1'b0);
        chk_both("R5 cin=0 steer", 17'h0FFFF);

        apply(16'h0000, 16'h0000, 1'b1);
        chk_both("R6 zero cin1", 17'h00001);
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        chk_both("R6 ones cin0", 17'h1FFFE);
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        chk_both("R6 ones cin1", 17'h1FFFF);

        for (int k = 0; k < 16; k++) begin
            apply(16'(1) << k, 16'(1) << k, 1'b0);
            chk_both("R7 carry hop", 17'(1) << (k + 1));
        end

        for (int n = 0; n < 10000; n++) begin
            x = 16'($urandom);
            y = 16'($urandom);
            c = 1'($urandom);
            apply(x, y, c);
            chk("R2 random uniform", {16'd0, co_uni, s_uni}, {16'd0, ref16(x, y, c)});
            chk("R3 random growing", {16'd0, co_grw, s_grw}, {16'd0, ref16(x, y, c)});
        end

        @(posedge clk);
        a32 = 32'h0000_0001; b32 = 32'hFFFF_FFFF; ci32 = 1'b0;
        @(negedge clk);
        chk("R8 chain longest", {co_hi, s_hi, s_lo}, 33'h1_0000_0000);

        for (int n = 0; n < 2000; n++) begin
            @(posedge clk);
            a32 = $urandom; b32 = $urandom; ci32 = 1'($urandom);
            @(negedge clk);
            chk("R8 chain random", {co_hi, s_hi, s_lo}, ref32(a32, b32, ci32));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule